// File: doc/BRIEF.md
# Dual Virtual Staging Queue with Deferred Fill

This block stages work items in front of a compute engine. One shared storage array of fixed-size entries is split into two circular queues. The split point can be moved at runtime. A controller reserves an entry in either queue before the data for it exists. The block returns the index of the reserved entry and records a destination tag for it. Data words then arrive later, in any order, through a write port addressed by entry index and word index.

Each word carries its own ready flag. An entry is complete only when all of its words have been written. One dequeue port serves one queue at a time. It presents the head entry of the active queue, together with that entry's destination tag, once that head entry is complete. Entries leave each queue strictly in reservation order.

The active queue changes lazily. The consumer must first have gone a fixed number of consecutive cycles without taking an entry, and the other queue must have a complete head entry waiting. This keeps queue changes rare while the engine is busy.

Top module: `dvq_top`

## Requirements
- R1: After reset, both queues are empty, `deqValid` is low, queue 0 owns entries 0 to ENTRIES/2-1, queue 1 owns the rest, and queue 0 is the active queue.
- R2: A granted reservation returns the queue's current tail index in the same cycle. Successive reservations in one queue return consecutive indices that wrap from the end of the queue's region back to its start.
- R3: A reservation is refused (`allocGrant` low, no state change) when the chosen queue already holds as many entries as its region has.
- R4: A split request (`cfgReq`, `cfgSplit` = number of entries owned by queue 0) takes effect only when both queues are empty, no reservation is requested in the same cycle, and `cfgSplit` <= ENTRIES. When it takes effect, both queues restart at the base of their regions. Otherwise it is ignored.
- R5: An entry counts as complete only when all WORDS of its words have been written. Word w of an entry appears on `deqData` bits [w*WORD_W +: WORD_W].
- R6: Each queue releases entries in reservation order. A complete entry behind an incomplete head is not presented.
- R7: While `deqValid` is high, `deqData`, `deqDest` and `deqQueue` show the active queue's head entry, the tag given when it was reserved, and the active queue number. The entry leaves on a cycle with `deqValid` and `deqReady` both high.
- R8: Releasing an entry clears all of its word ready flags, so a later reservation of the same index is not complete until it is fully written again.
- R9: Only the active queue is presented. A complete head in the other queue is not shown while the active queue is selected.
- R10: Each clock edge without a release adds one to an idle count, which saturates at IDLE_LIMIT. A release clears the count. The active queue flips on an edge where the count equals IDLE_LIMIT, no release occurs, and the other queue's head is complete. With IDLE_LIMIT = 16, the switch falls on the 17th edge after the last release.
- R11: No switch happens while the other queue's head entry is incomplete or that queue is empty, however long the consumer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocReq | input | 1 | Reserve one entry |
| allocQueue | input | 1 | Queue to reserve in |
| allocDest | input | DEST_W | Destination tag stored with the entry |
| allocGrant | output | 1 | Reservation accepted this cycle |
| allocIdx | output | $clog2(ENTRIES) | Index of the reserved entry |
| cfgReq | input | 1 | Request a new split |
| cfgSplit | input | $clog2(ENTRIES+1) | Entries owned by queue 0 |
| wrEn | input | 1 | Write one data word |
| wrIdx | input | $clog2(ENTRIES) | Entry index of the write |
| wrWord | input | $clog2(WORDS) | Word index inside the entry |
| wrData | input | WORD_W | Data word |
| deqValid | output | 1 | Active head entry is complete |
| deqReady | input | 1 | Consumer takes the presented entry |
| deqData | output | WORDS*WORD_W | Presented entry, word 0 in the low bits |
| deqDest | output | DEST_W | Destination tag of the presented entry |
| deqQueue | output | 1 | Queue the presented entry belongs to |

## Verification
The bench fills an entry out of order, with a complete entry sitting behind a half-written head. A design that tracked readiness per queue instead of per head entry would release early, and the bench would see out-of-order data. It wraps a queue past the end of its region and then overfills it; wrong wrap arithmetic would hand out indices in the other queue's region, and a weak full test would over-allocate. It reuses released indices without rewriting them, which catches ready flags that survive a release. It measures the exact edge of a lazy queue switch and holds the other queue's head half written for a long idle spell, which exposes an off-by-one idle count or a switch that ignores readiness. A split request made while entries are outstanding must leave queue 1 starting at the old boundary.

// File: rtl/dvq_pkg.sv
package dvq_pkg;
  // Strobes from the control path to the storage path
  typedef struct packed {
    logic allocWe;
    logic popEn;
  } dvqStrobe_t;
endpackage

// File: rtl/dvq_ctrl.sv
module dvq_ctrl
  import dvq_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int IDLE_LIMIT = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1),
  localparam int TW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocReq,
  input  logic               allocQueue,
  input  logic               cfgReq,
  input  logic [CW-1:0]      cfgSplit,
  input  logic               deqReady,
  input  logic [ENTRIES-1:0] entryReady,
  output logic               allocGrant,
  output logic [IW-1:0]      allocIdx,
  output logic [IW-1:0]      popIdx,
  output logic               deqValid,
  output logic               deqQueue,
  output dvqStrobe_t         strobe
);
  logic [CW-1:0] split;
  logic [CW-1:0] count   [2];
  logic [CW-1:0] size    [2];
  logic [CW-1:0] base    [2];
  logic [IW-1:0] headOff [2];
  logic [IW-1:0] headIdx [2];
  logic [IW-1:0] tailIdx [2];
  logic [CW:0]   tailSum [2];
  logic [1:0]    headRdy;
  logic          activeQ;
  logic [TW-1:0] idleCnt;
  logic          popEn, cfgOk, switchNow;

  assign size[0] = split;
  assign size[1] = CW'(ENTRIES) - split;
  assign base[0] = '0;
  assign base[1] = split;

  always_comb begin
    for (int q = 0; q < 2; q++) begin
      tailSum[q] = (CW+1)'(headOff[q]) + (CW+1)'(count[q]);
      if (tailSum[q] >= (CW+1)'(size[q])) tailSum[q] = tailSum[q] - (CW+1)'(size[q]);
      tailIdx[q] = IW'(base[q] + tailSum[q][CW-1:0]);
      headIdx[q] = IW'(base[q] + CW'(headOff[q]));
      headRdy[q] = (count[q] != '0) && entryReady[headIdx[q]];
    end
  end

  assign allocGrant = allocReq && (count[allocQueue] < size[allocQueue]);
  assign allocIdx   = tailIdx[allocQueue];
  assign cfgOk      = cfgReq && !allocReq && (count[0] == '0) && (count[1] == '0)
                      && (cfgSplit <= CW'(ENTRIES));
  assign deqValid   = headRdy[activeQ];
  assign deqQueue   = activeQ;
  assign popEn      = deqValid && deqReady;
  assign popIdx     = headIdx[activeQ];
  assign switchNow  = !popEn && (idleCnt == TW'(IDLE_LIMIT)) && headRdy[~activeQ];

  assign strobe.allocWe = allocGrant;
  assign strobe.popEn   = popEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      split <= CW'(ENTRIES / 2);
      for (int q = 0; q < 2; q++) begin
        count[q]   <= '0;
        headOff[q] <= '0;
      end
    end else begin
      if (cfgOk) split <= cfgSplit;
      for (int q = 0; q < 2; q++) begin
        if (cfgOk) headOff[q] <= '0;
        else if (popEn && (activeQ == q[0]))
          headOff[q] <= (CW'(headOff[q]) + 1'b1 == size[q]) ? '0 : headOff[q] + 1'b1;
        count[q] <= count[q] + CW'(allocGrant && (allocQueue == q[0]))
                             - CW'(popEn && (activeQ == q[0]));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      idleCnt <= '0;
    end else if (popEn) begin
      idleCnt <= '0;
    end else if (switchNow) begin
      activeQ <= ~activeQ;
      idleCnt <= '0;
    end else if (idleCnt != TW'(IDLE_LIMIT)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count[0] <= size[0]) && (count[1] <= size[1]));

  // R4
  split_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (split != $past(split)) |-> (($past(count[0]) == '0) && ($past(count[1]) == '0)));

  // R10
  switch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ != $past(activeQ)) |-> (!$past(popEn) && ($past(idleCnt) == TW'(IDLE_LIMIT))));

  // R11
  switch_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ != $past(activeQ)) |-> $past(headRdy[~activeQ]));
endmodule

// File: rtl/dvq_data.sv
module dvq_data
  import dvq_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORDS   = 2,
  parameter int WORD_W  = 32,
  parameter int DEST_W  = 6,
  localparam int IW = $clog2(ENTRIES),
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dvqStrobe_t              strobe,
  input  logic [IW-1:0]           allocIdx,
  input  logic [DEST_W-1:0]       allocDest,
  input  logic [IW-1:0]           popIdx,
  input  logic                    wrEn,
  input  logic [IW-1:0]           wrIdx,
  input  logic [WW-1:0]           wrWord,
  input  logic [WORD_W-1:0]       wrData,
  output logic [ENTRIES-1:0]      entryReady,
  output logic [WORDS*WORD_W-1:0] deqData,
  output logic [DEST_W-1:0]       deqDest
);
  logic [WORD_W-1:0] mem     [ENTRIES][WORDS];
  logic [DEST_W-1:0] destMem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx][wrWord] <= wrData;
    if (strobe.allocWe) destMem[allocIdx] <= allocDest;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [WORDS-1:0] rdy;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdy <= '0;
      else begin
        if (strobe.popEn && (popIdx == IW'(e))) rdy <= '0;
        if (wrEn && (wrIdx == IW'(e))) rdy[wrWord] <= 1'b1;
      end
    end
    assign entryReady[e] = &rdy;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign deqData[w*WORD_W +: WORD_W] = mem[popIdx][w];
  end
  assign deqDest = destMem[popIdx];

  // R5
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popEn |-> entryReady[popIdx]);

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popEn && !(wrEn && (wrIdx == popIdx))) |=> !entryReady[$past(popIdx)]);
endmodule

// File: rtl/dvq_top.sv
module dvq_top
  import dvq_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int WORDS      = 2,
  parameter int WORD_W     = 32,
  parameter int DEST_W     = 6,
  parameter int IDLE_LIMIT = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1),
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allocReq,
  input  logic                    allocQueue,
  input  logic [DEST_W-1:0]       allocDest,
  output logic                    allocGrant,
  output logic [IW-1:0]           allocIdx,
  input  logic                    cfgReq,
  input  logic [CW-1:0]           cfgSplit,
  input  logic                    wrEn,
  input  logic [IW-1:0]           wrIdx,
  input  logic [WW-1:0]           wrWord,
  input  logic [WORD_W-1:0]       wrData,
  output logic                    deqValid,
  input  logic                    deqReady,
  output logic [WORDS*WORD_W-1:0] deqData,
  output logic [DEST_W-1:0]       deqDest,
  output logic                    deqQueue
);
  dvqStrobe_t         strobe;
  logic [ENTRIES-1:0] entryReady;
  logic [IW-1:0]      popIdx;

  dvq_ctrl #(.ENTRIES(ENTRIES), .IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocQueue(allocQueue),
    .cfgReq(cfgReq), .cfgSplit(cfgSplit), .deqReady(deqReady),
    .entryReady(entryReady), .allocGrant(allocGrant), .allocIdx(allocIdx),
    .popIdx(popIdx), .deqValid(deqValid), .deqQueue(deqQueue), .strobe(strobe)
  );

  dvq_data #(.ENTRIES(ENTRIES), .WORDS(WORDS), .WORD_W(WORD_W), .DEST_W(DEST_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .allocDest(allocDest), .popIdx(popIdx), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrWord(wrWord), .wrData(wrData), .entryReady(entryReady),
    .deqData(deqData), .deqDest(deqDest)
  );
endmodule

// File: tb/tb_dvq_top.sv
module tb_dvq_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16, WORDS = 2, WORD_W = 32, DEST_W = 6, IDLE_LIMIT = 16;
  localparam int IW = $clog2(ENTRIES), CW = $clog2(ENTRIES + 1), WW = $clog2(WORDS);
  localparam int DW = WORDS * WORD_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocReq = 0, allocQueue = 0, cfgReq = 0, wrEn = 0, deqReady = 0;
  logic [DEST_W-1:0] allocDest = '0;
  logic [CW-1:0] cfgSplit = '0;
  logic [IW-1:0] wrIdx = '0;
  logic [WW-1:0] wrWord = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic allocGrant, deqValid, deqQueue;
  logic [IW-1:0] allocIdx;
  logic [DW-1:0] deqData;
  logic [DEST_W-1:0] deqDest;

  dvq_top #(.ENTRIES(ENTRIES), .WORDS(WORDS), .WORD_W(WORD_W), .DEST_W(DEST_W),
            .IDLE_LIMIT(IDLE_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocQueue(allocQueue),
    .allocDest(allocDest), .allocGrant(allocGrant), .allocIdx(allocIdx),
    .cfgReq(cfgReq), .cfgSplit(cfgSplit), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrWord(wrWord), .wrData(wrData), .deqValid(deqValid), .deqReady(deqReady),
    .deqData(deqData), .deqDest(deqDest), .deqQueue(deqQueue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { logic [DEST_W-1:0] dest; logic [DW-1:0] data; } item_t;
  item_t sb0[$], sb1[$];
  int cyc = 0, checks = 0, errors = 0, popCount = 0, popCyc = 0, serial = 0;
  int saltOf[ENTRIES];
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] wordVal(int idx, int w);
    return {8'(saltOf[idx]), 8'(idx), 8'(w), 8'hA5};
  endfunction

  // Monitor: handshake seen at negedge leaves at the following posedge (R7)
  always @(negedge clk) begin
    if (rstN && deqValid && deqReady) begin
      item_t exp;
      popCyc = cyc;
      popCount++;
      if (deqQueue ? sb1.size() == 0 : sb0.size() == 0) begin
        check(0, "R7", "unexpected entry", longint'(deqQueue), 0);
      end else begin
        exp = deqQueue ? sb1.pop_front() : sb0.pop_front();
        check(deqData == exp.data, "R7", "deqData", longint'(deqData), longint'(exp.data));
        check(deqDest == exp.dest, "R7", "deqDest", longint'(deqDest), longint'(exp.dest));
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doAlloc(bit q, int dest, output bit ok, output int idx);
    item_t it;
    allocReq = 1; allocQueue = q; allocDest = DEST_W'(dest);
    #1;
    ok = allocGrant; idx = int'(allocIdx);
    if (ok) begin
      serial++;
      saltOf[idx] = serial;
      it.dest = DEST_W'(dest);
      for (int w = 0; w < WORDS; w++) it.data[w*WORD_W +: WORD_W] = wordVal(idx, w);
      if (q) sb1.push_back(it); else sb0.push_back(it);
    end
    @(posedge clk); #1;
    allocReq = 0;
  endtask

  task automatic doWrite(int idx, int w);
    wrEn = 1; wrIdx = IW'(idx); wrWord = WW'(w); wrData = wordVal(idx, w);
    step();
    wrEn = 0;
  endtask

  task automatic fillEntry(int idx);
    for (int w = WORDS - 1; w >= 0; w--) doWrite(idx, w);
  endtask

  task automatic waitPops(int target, int limit, string req);
    int n = 0;
    while (popCount < target && n < limit) begin step(); n++; end
    check(popCount == target, req, "release count", popCount, target);
  endtask

  initial begin
    bit ok;
    int idx;
    step(3);
    rstN = 1;
    step();
    // R1: reset state
    check(deqValid == 0, "R1", "deqValid after reset", deqValid, 0);
    check(deqQueue == 0, "R1", "active queue after reset", deqQueue, 0);

    // R2: consecutive reservations in queue 0, first at index 0 (R1)
    for (int i = 0; i < 4; i++) begin
      doAlloc(0, 10 + i, ok, idx);
      check(ok && idx == i, "R2", "q0 reserve index", idx, i);
    end
    // R6: complete entry 1 behind half-written head 0
    fillEntry(1);
    doWrite(0, 0);
    check(deqValid == 0, "R6", "blocked by incomplete head", deqValid, 0);
    check(deqValid == 0, "R5", "half-written entry not complete", deqValid, 0);
    doWrite(0, 1);
    check(deqValid == 1, "R5", "complete head presented", deqValid, 1);
    check(deqDest == 10, "R7", "head dest", deqDest, 10);
    fillEntry(2);
    fillEntry(3);
    deqReady = 1;
    waitPops(4, 40, "R6");

    // R2: wrap inside the queue 0 region, R3: refusal when full
    for (int i = 0; i < 8; i++) begin
      doAlloc(0, 20 + i, ok, idx);
      check(ok && idx == (4 + i) % 8, "R2", "q0 wrapped index", idx, (4 + i) % 8);
    end
    doAlloc(0, 63, ok, idx);
    check(ok == 0, "R3", "reserve in full queue", ok, 0);
    // R4: split request with queue 0 busy must be ignored
    cfgReq = 1; cfgSplit = CW'(4);
    step();
    cfgReq = 0;
    for (int i = 4; i < 8; i++) fillEntry(i);
    waitPops(8, 40, "R3");
    step(3);
    // R8: indices 0..3 were released before, not rewritten yet
    check(deqValid == 0, "R8", "reused entry not complete", deqValid, 0);
    for (int i = 0; i < 4; i++) fillEntry(i);
    waitPops(12, 40, "R8");

    // R4: queue 1 still starts at the old boundary
    doAlloc(1, 33, ok, idx);
    check(ok && idx == 8, "R4", "q1 base after ignored split", idx, 8);
    fillEntry(8);
    check(deqValid == 0, "R9", "other queue not presented", deqValid, 0);
    // R10: switch lands on the 17th edge after the last release
    begin
      int n = 0;
      while (!deqValid && n < 60) begin @(negedge clk); n++; end
      check(deqValid && deqQueue == 1, "R10", "switched to queue 1", deqQueue, 1);
      check(cyc - popCyc == 18, "R10", "switch edge distance", cyc - popCyc, 18);
    end
    step();
    waitPops(13, 20, "R10");

    // R11: queue 0 head half written, no switch however long
    doAlloc(0, 44, ok, idx);
    check(ok && idx == 4, "R2", "q0 index after wraps", idx, 4);
    doWrite(4, 0);
    step(30);
    check(deqValid == 0, "R11", "no switch to incomplete head", deqValid, 0);
    check(deqQueue == 1, "R11", "active queue kept", deqQueue, 1);
    doAlloc(1, 45, ok, idx);
    check(ok && idx == 9, "R2", "q1 second index", idx, 9);
    fillEntry(9);
    waitPops(14, 10, "R9");
    doWrite(4, 1);
    waitPops(15, 40, "R11");

    // R4: accepted split when both queues are empty
    cfgReq = 1; cfgSplit = CW'(4);
    step();
    cfgReq = 0;
    doAlloc(1, 50, ok, idx);
    check(ok && idx == 4, "R4", "q1 base after split", idx, 4);
    for (int i = 0; i < 4; i++) begin
      doAlloc(0, 51 + i, ok, idx);
      check(ok && idx == i, "R4", "q0 index in narrowed region", idx, i);
    end
    doAlloc(0, 60, ok, idx);
    check(ok == 0, "R3", "narrowed q0 full", ok, 0);
    fillEntry(4);
    for (int i = 0; i < 4; i++) fillEntry(i);
    waitPops(20, 80, "R4");
    check(sb0.size() == 0 && sb1.size() == 0, "R7", "scoreboard drained",
          sb0.size() + sb1.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule